// File: doc/BRIEF.md
# Firmware Upgrade Request Controller

This block is the control-plane sequencer for firmware-upgrade class requests arriving on the USB default control pipe. A setup decoder in front of it presents one decoded request per cycle: request type, request code, wValue and wLength. The block checks each request against its current state, updates that state and the stored status, and answers status and state queries with ready-packed response bytes. It raises start strobes toward the memory back end when a download or upload block is accepted. It raises an abort strobe when a transfer is cancelled. Requests that are not allowed in the current state are refused with a stall.

The memory back end reports back through a done pulse and an error pulse with a 4-bit error code. A bus-reset input finishes the detach and wait-for-reset phases. Payload movement, descriptor service and the programming of non-volatile memory are handled by neighbouring blocks. The poll timeout sent in status responses comes from a configuration input.

Top module: `dfu_req_fsm`

## Requirements
- R1: After reset, state_o is 2 (idle in upgrade mode, the default), status_o is 0 (OK), and stall_o, dn_start_o, up_start_o, abort_o, status_vld_o and state_vld_o are all 0.
- R2: The request codes are detach 0, download 1, upload 2, get-status 3, clear-status 4, get-state 5 and abort 6. Codes 0, 1, 4 and 6 need type 21h. Codes 2, 3 and 5 need type A1h. Any other code, or a code paired with the wrong type, is illegal.
- R3: A download request with wLength greater than 0, in state 2 or 5, pulses dn_start_o for one cycle and moves to state 3. It also latches wValue on blk_num_o and wLength on xfer_len_o.
- R4: A get-status request in state 3 moves to state 4 if the memory has not yet reported done for the current block, and to state 5 if it has. A done pulse in state 4 moves back to state 3.
- R5: A get-status request pulses status_vld_o. status_resp_o then carries the status in bits 7:0, the poll timeout least-significant byte first in bits 31:8, the state entered after the request in bits 39:32, and the string index parameter in bits 47:40.
- R6: A get-state request pulses state_vld_o, puts the current state on state_resp_o, and leaves the state and status unchanged.
- R7: A download request with wLength 0 in state 5 moves to state 6. Get-status in state 6 moves to state 7. A done pulse in state 7 moves to state 8. A bus reset in state 8 moves to state 0. Download with wLength 0 in state 2 is illegal.
- R8: Every illegal request sets status 0Fh, enters state 10 and pulses stall_o. In state 10, only clear-status, get-status and get-state are legal. Clear-status sets status 0 and returns to state 2.
- R9: Abort in state 2, 5 or 9 returns to state 2, sets status 0 and pulses abort_o. In any other state it is illegal.
- R10: An error pulse in state 3, 4, 7 or 9 enters state 10 with status equal to mem_err_code_i, without a stall.
- R11: An upload request with wLength greater than 0, in state 2 or 9, pulses up_start_o and enters state 9. A done pulse in state 9 returns to state 2.
- R12: Detach is legal only in state 0 and moves to state 1. A bus reset in state 1 moves to state 2.
- R13: A memory done pulse has no effect on state or status in states 2, 5 and 10. Clear-status outside state 10 is illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| setup_valid_i | input | 1 | One-cycle pulse: a decoded request is present |
| req_type_i | input | 8 | Request type byte |
| req_code_i | input | 8 | Request code byte |
| req_value_i | input | 16 | wValue of the request |
| req_len_i | input | 16 | wLength of the request |
| mem_done_i | input | 1 | Memory back end finished the current operation |
| mem_err_i | input | 1 | Memory back end failed the current operation |
| mem_err_code_i | input | 4 | Status code reported with mem_err_i |
| bus_reset_i | input | 1 | USB bus reset seen |
| poll_ms_i | input | 24 | Poll timeout in milliseconds for status responses |
| state_o | output | 4 | Current state |
| status_o | output | 4 | Current status code |
| stall_o | output | 1 | Pulse: last request refused |
| dn_start_o | output | 1 | Pulse: download block accepted |
| up_start_o | output | 1 | Pulse: upload block accepted |
| abort_o | output | 1 | Pulse: transfer aborted |
| blk_num_o | output | 16 | Block number of the last accepted transfer |
| xfer_len_o | output | 16 | Length of the last accepted transfer |
| status_resp_o | output | 48 | Six-byte status response, byte 0 in bits 7:0 |
| status_vld_o | output | 1 | Pulse: status_resp_o refreshed |
| state_resp_o | output | 8 | One-byte state response |
| state_vld_o | output | 1 | Pulse: state_resp_o refreshed |

## Verification
On every cycle, the assertions check several things. Any stall coincides with the error state and status 0Fh. The error state is left only through a clear-status request. At most one strobe fires at a time. Each start strobe lands in the matching state, and each abort lands in idle with OK status. The state byte of a status response matches the state then held. A state query never moves the state. The bench scenarios cover the rest: the order of the download handshake, whether a done pulse arrived early or late, the full manifestation path through bus reset, memory-reported error codes, the byte layout of the poll timeout, and inputs that must be ignored.

// File: rtl/dfu_pkg.sv
package dfu_pkg;
  typedef enum logic [3:0] {
    ST_APP_IDLE   = 4'd0,
    ST_APP_DETACH = 4'd1,
    ST_IDLE       = 4'd2,
    ST_DN_SYNC    = 4'd3,
    ST_DN_BUSY    = 4'd4,
    ST_DN_IDLE    = 4'd5,
    ST_MAN_SYNC   = 4'd6,
    ST_MAN        = 4'd7,
    ST_MAN_WAIT   = 4'd8,
    ST_UP_IDLE    = 4'd9,
    ST_ERROR      = 4'd10
  } dfu_state_e;

  typedef enum logic [2:0] {
    RQ_DETACH    = 3'd0,
    RQ_DNLOAD    = 3'd1,
    RQ_UPLOAD    = 3'd2,
    RQ_GETSTATUS = 3'd3,
    RQ_CLRSTATUS = 3'd4,
    RQ_GETSTATE  = 3'd5,
    RQ_ABORT     = 3'd6,
    RQ_BAD       = 3'd7
  } req_kind_e;

  localparam logic [7:0] TYPE_H2D    = 8'h21;
  localparam logic [7:0] TYPE_D2H    = 8'hA1;
  localparam logic [3:0] STS_OK      = 4'h0;
  localparam logic [3:0] STS_STALLED = 4'hF;
endpackage

// File: rtl/dfu_req_decode.sv
module dfu_req_decode
  import dfu_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic [7:0]       req_type_i,
  input  logic [7:0]       req_code_i,
  input  logic [LEN_W-1:0] req_len_i,
  output req_kind_e        kind_o,
  output logic             len_zero_o
);
  logic       code_ok;
  logic       dir_in;
  logic [7:0] need_type;

  assign code_ok    = (req_code_i[7:3] == 5'd0) && (req_code_i[2:0] != 3'd7);
  // upload, get-status and get-state move data toward the host
  assign dir_in     = (req_code_i[2:0] == 3'd2) || (req_code_i[2:0] == 3'd3) ||
                      (req_code_i[2:0] == 3'd5);
  assign need_type  = dir_in ? TYPE_D2H : TYPE_H2D;
  assign len_zero_o = (req_len_i == '0);

  always_comb begin
    if (code_ok && (req_type_i == need_type)) kind_o = req_kind_e'(req_code_i[2:0]);
    else                                      kind_o = RQ_BAD;
  end
endmodule

// File: rtl/dfu_state_ctrl.sv
module dfu_state_ctrl
  import dfu_pkg::*;
#(
  parameter bit START_IN_DFU = 1'b1,
  parameter int VAL_W        = 16,
  parameter int LEN_W        = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_vld_i,
  input  req_kind_e        kind_i,
  input  logic             len_zero_i,
  input  logic [VAL_W-1:0] req_value_i,
  input  logic [LEN_W-1:0] req_len_i,
  input  logic             mem_done_i,
  input  logic             mem_err_i,
  input  logic [3:0]       mem_err_code_i,
  input  logic             bus_reset_i,
  output dfu_state_e       state_o,
  output dfu_state_e       nxt_state_o,
  output logic [3:0]       status_o,
  output logic [3:0]       nxt_status_o,
  output logic             stat_req_o,
  output logic             state_req_o,
  output logic             stall_o,
  output logic             dn_start_o,
  output logic             up_start_o,
  output logic             abort_o,
  output logic [VAL_W-1:0] blk_num_o,
  output logic [LEN_W-1:0] xfer_len_o
);
  localparam dfu_state_e RST_ST = START_IN_DFU ? ST_IDLE : ST_APP_IDLE;

  dfu_state_e state_q, nxt_state;
  logic [3:0] status_q, nxt_status;
  logic       blk_done_q, blk_done_d;
  logic       ill, dn, up, ab, gs, gst, busy;

  assign busy = (state_q == ST_DN_BUSY) || (state_q == ST_MAN) || (state_q == ST_MAN_WAIT);

  always_comb begin
    nxt_state  = state_q;
    nxt_status = status_q;
    blk_done_d = blk_done_q;
    ill = 1'b0; dn = 1'b0; up = 1'b0; ab = 1'b0; gs = 1'b0; gst = 1'b0;
    if (bus_reset_i) begin
      if (state_q == ST_APP_DETACH)    nxt_state = ST_IDLE;
      else if (state_q == ST_MAN_WAIT) nxt_state = ST_APP_IDLE;
    end else if (req_vld_i) begin
      case (kind_i)
        RQ_DETACH: begin
          if (state_q == ST_APP_IDLE) nxt_state = ST_APP_DETACH;
          else ill = 1'b1;
        end
        RQ_DNLOAD: begin
          if (state_q == ST_IDLE && !len_zero_i) begin
            nxt_state = ST_DN_SYNC; dn = 1'b1;
          end else if (state_q == ST_DN_IDLE) begin
            if (len_zero_i) nxt_state = ST_MAN_SYNC;
            else begin nxt_state = ST_DN_SYNC; dn = 1'b1; end
          end else ill = 1'b1;
        end
        RQ_UPLOAD: begin
          if ((state_q == ST_IDLE || state_q == ST_UP_IDLE) && !len_zero_i) begin
            nxt_state = ST_UP_IDLE; up = 1'b1;
          end else ill = 1'b1;
        end
        RQ_GETSTATUS: begin
          if (busy) ill = 1'b1;
          else begin
            gs = 1'b1;
            if (state_q == ST_DN_SYNC)
              nxt_state = blk_done_q ? ST_DN_IDLE : ST_DN_BUSY;
            else if (state_q == ST_MAN_SYNC)
              nxt_state = ST_MAN;
          end
        end
        RQ_CLRSTATUS: begin
          if (state_q == ST_ERROR) begin nxt_state = ST_IDLE; nxt_status = STS_OK; end
          else ill = 1'b1;
        end
        RQ_GETSTATE: begin
          if (busy) ill = 1'b1;
          else gst = 1'b1;
        end
        RQ_ABORT: begin
          if (state_q == ST_IDLE || state_q == ST_DN_IDLE || state_q == ST_UP_IDLE) begin
            nxt_state = ST_IDLE; nxt_status = STS_OK; ab = 1'b1;
          end else ill = 1'b1;
        end
        default: ill = 1'b1;
      endcase
      if (ill) begin
        nxt_state = ST_ERROR; nxt_status = STS_STALLED; gs = 1'b0; gst = 1'b0;
      end
    end else if (mem_err_i && (state_q == ST_DN_SYNC || state_q == ST_DN_BUSY ||
                               state_q == ST_MAN || state_q == ST_UP_IDLE)) begin
      nxt_state  = ST_ERROR;
      nxt_status = mem_err_code_i;
    end else if (mem_done_i) begin
      case (state_q)
        ST_DN_SYNC: blk_done_d = 1'b1;
        ST_DN_BUSY: begin nxt_state = ST_DN_SYNC; blk_done_d = 1'b1; end
        ST_MAN:     nxt_state = ST_MAN_WAIT;
        ST_UP_IDLE: nxt_state = ST_IDLE;
        default:    ;
      endcase
    end
    if (dn) blk_done_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= RST_ST;
      status_q   <= STS_OK;
      blk_done_q <= 1'b0;
      stall_o    <= 1'b0;
      dn_start_o <= 1'b0;
      up_start_o <= 1'b0;
      abort_o    <= 1'b0;
      blk_num_o  <= '0;
      xfer_len_o <= '0;
    end else begin
      state_q    <= nxt_state;
      status_q   <= nxt_status;
      blk_done_q <= blk_done_d;
      stall_o    <= ill;
      dn_start_o <= dn;
      up_start_o <= up;
      abort_o    <= ab;
      if (dn || up) begin
        blk_num_o  <= req_value_i;
        xfer_len_o <= req_len_i;
      end
    end
  end

  assign state_o      = state_q;
  assign status_o     = status_q;
  assign nxt_state_o  = nxt_state;
  assign nxt_status_o = nxt_status;
  assign stat_req_o   = gs;
  assign state_req_o  = gst;
endmodule

// File: rtl/dfu_resp_pack.sv
module dfu_resp_pack
  import dfu_pkg::*;
#(
  parameter logic [7:0] STR_IDX = 8'h00,
  parameter int         POLL_W  = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stat_req_i,
  input  logic              state_req_i,
  input  dfu_state_e        cur_state_i,
  input  dfu_state_e        nxt_state_i,
  input  logic [3:0]        nxt_status_i,
  input  logic [POLL_W-1:0] poll_ms_i,
  output logic [POLL_W+23:0] status_resp_o,
  output logic              status_vld_o,
  output logic [7:0]        state_resp_o,
  output logic              state_vld_o
);
  localparam int POLL_BYTES = POLL_W / 8;

  logic [POLL_W-1:0] poll_le;

  // bytes leave lowest first, so byte b of the timeout lands at byte b+1 of the reply
  for (genvar b = 0; b < POLL_BYTES; b++) begin : g_poll
    assign poll_le[8*b +: 8] = poll_ms_i[8*b +: 8];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_resp_o <= '0;
      status_vld_o  <= 1'b0;
      state_resp_o  <= '0;
      state_vld_o   <= 1'b0;
    end else begin
      status_vld_o <= stat_req_i;
      state_vld_o  <= state_req_i;
      if (stat_req_i)
        status_resp_o <= {STR_IDX, 4'h0, nxt_state_i, poll_le, 4'h0, nxt_status_i};
      if (state_req_i)
        state_resp_o <= {4'h0, cur_state_i};
    end
  end
endmodule

// File: rtl/dfu_req_fsm.sv
module dfu_req_fsm
  import dfu_pkg::*;
#(
  parameter bit         START_IN_DFU = 1'b1,
  parameter logic [7:0] STR_IDX      = 8'h00,
  parameter int         VAL_W        = 16,
  parameter int         LEN_W        = 16,
  parameter int         POLL_W       = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              setup_valid_i,
  input  logic [7:0]        req_type_i,
  input  logic [7:0]        req_code_i,
  input  logic [VAL_W-1:0]  req_value_i,
  input  logic [LEN_W-1:0]  req_len_i,
  input  logic              mem_done_i,
  input  logic              mem_err_i,
  input  logic [3:0]        mem_err_code_i,
  input  logic              bus_reset_i,
  input  logic [POLL_W-1:0] poll_ms_i,
  output logic [3:0]        state_o,
  output logic [3:0]        status_o,
  output logic              stall_o,
  output logic              dn_start_o,
  output logic              up_start_o,
  output logic              abort_o,
  output logic [VAL_W-1:0]  blk_num_o,
  output logic [LEN_W-1:0]  xfer_len_o,
  output logic [POLL_W+23:0] status_resp_o,
  output logic              status_vld_o,
  output logic [7:0]        state_resp_o,
  output logic              state_vld_o
);
  req_kind_e  kind;
  logic       len_zero;
  dfu_state_e cur_state, nxt_state;
  logic [3:0] nxt_status;
  logic       stat_req, state_req;

  dfu_req_decode #(.LEN_W(LEN_W)) u_dec (
    .req_type_i (req_type_i),
    .req_code_i (req_code_i),
    .req_len_i  (req_len_i),
    .kind_o     (kind),
    .len_zero_o (len_zero)
  );

  dfu_state_ctrl #(
    .START_IN_DFU(START_IN_DFU), .VAL_W(VAL_W), .LEN_W(LEN_W)
  ) u_ctrl (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .req_vld_i      (setup_valid_i),
    .kind_i         (kind),
    .len_zero_i     (len_zero),
    .req_value_i    (req_value_i),
    .req_len_i      (req_len_i),
    .mem_done_i     (mem_done_i),
    .mem_err_i      (mem_err_i),
    .mem_err_code_i (mem_err_code_i),
    .bus_reset_i    (bus_reset_i),
    .state_o        (cur_state),
    .nxt_state_o    (nxt_state),
    .status_o       (status_o),
    .nxt_status_o   (nxt_status),
    .stat_req_o     (stat_req),
    .state_req_o    (state_req),
    .stall_o        (stall_o),
    .dn_start_o     (dn_start_o),
    .up_start_o     (up_start_o),
    .abort_o        (abort_o),
    .blk_num_o      (blk_num_o),
    .xfer_len_o     (xfer_len_o)
  );

  dfu_resp_pack #(.STR_IDX(STR_IDX), .POLL_W(POLL_W)) u_resp (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .stat_req_i    (stat_req),
    .state_req_i   (state_req),
    .cur_state_i   (cur_state),
    .nxt_state_i   (nxt_state),
    .nxt_status_i  (nxt_status),
    .poll_ms_i     (poll_ms_i),
    .status_resp_o (status_resp_o),
    .status_vld_o  (status_vld_o),
    .state_resp_o  (state_resp_o),
    .state_vld_o   (state_vld_o)
  );

  assign state_o = cur_state;
endmodule

// File: rtl/dfu_req_chk.sv
module dfu_req_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        setup_valid_i,
  input logic [7:0]  req_type_i,
  input logic [7:0]  req_code_i,
  input logic [3:0]  state_o,
  input logic [3:0]  status_o,
  input logic        stall_o,
  input logic        dn_start_o,
  input logic        up_start_o,
  input logic        abort_o,
  input logic [47:0] status_resp_o,
  input logic        status_vld_o,
  input logic [7:0]  state_resp_o,
  input logic        state_vld_o
);
  // R8
  stall_in_error_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> (state_o == 4'd10 && status_o == 4'hF));

  // R8
  error_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state_o) == 4'd10 && state_o != 4'd10) |->
      $past(setup_valid_i && req_type_i == 8'h21 && req_code_i == 8'd4));

  // R3
  one_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({stall_o, dn_start_o, up_start_o, abort_o}));

  // R3
  dn_start_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dn_start_o |-> state_o == 4'd3);

  // R11
  up_start_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    up_start_o |-> state_o == 4'd9);

  // R9
  abort_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> (state_o == 4'd2 && status_o == 4'h0));

  // R5
  resp_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_vld_o |-> (status_resp_o[39:32] == {4'h0, state_o} &&
                      status_resp_o[7:0] == {4'h0, status_o}));

  // R6
  getstate_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_vld_o |-> (state_o == $past(state_o) && state_resp_o == {4'h0, state_o}));
endmodule

bind dfu_req_fsm dfu_req_chk u_chk (.*);

// File: tb/tb_dfu_req_fsm.sv
`timescale 1ns/1ps
module tb_dfu_req_fsm;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        setup_valid_i = 1'b0;
  logic [7:0]  req_type_i = '0;
  logic [7:0]  req_code_i = '0;
  logic [15:0] req_value_i = '0;
  logic [15:0] req_len_i = '0;
  logic        mem_done_i = 1'b0;
  logic        mem_err_i = 1'b0;
  logic [3:0]  mem_err_code_i = '0;
  logic        bus_reset_i = 1'b0;
  logic [23:0] poll_ms_i = 24'h030201;
  logic [3:0]  state_o, status_o;
  logic        stall_o, dn_start_o, up_start_o, abort_o;
  logic [15:0] blk_num_o, xfer_len_o;
  logic [47:0] status_resp_o;
  logic        status_vld_o, state_vld_o;
  logic [7:0]  state_resp_o;

  int total = 0;
  int bad = 0;

  always #2.5 clk_i = ~clk_i;

  dfu_req_fsm dut (.*);

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] t, input logic [7:0] c, input logic [15:0] v, input logic [15:0] l);
    @(negedge clk_i);
    req_type_i = t; req_code_i = c; req_value_i = v; req_len_i = l; setup_valid_i = 1'b1;
    @(negedge clk_i);
    setup_valid_i = 1'b0;
  endtask

  task automatic mem_done();
    @(negedge clk_i); mem_done_i = 1'b1;
    @(negedge clk_i); mem_done_i = 1'b0;
  endtask

  task automatic mem_fail(input logic [3:0] code);
    @(negedge clk_i); mem_err_i = 1'b1; mem_err_code_i = code;
    @(negedge clk_i); mem_err_i = 1'b0;
  endtask

  task automatic bus_rst();
    @(negedge clk_i); bus_reset_i = 1'b1;
    @(negedge clk_i); bus_reset_i = 1'b0;
  endtask

  task automatic expect_st(input string tag, input logic [3:0] st, input logic [3:0] sts, input bit stl);
    chk(state_o == st && status_o == sts && stall_o == stl, tag,
        {55'h0, stl, status_o, state_o}, {55'h0, stl, sts, st});
  endtask

  // {type, code, len, exp_state, exp_status, exp_stall}
  localparam int NV = 17;
  localparam logic [40:0] VEC [NV] = '{
    {8'hA1, 8'd5, 16'd1,  4'd2,  4'h0, 1'b0},  // R6 get-state in idle
    {8'h21, 8'd1, 16'd0,  4'd10, 4'hF, 1'b1},  // R7 zero download in idle
    {8'hA1, 8'd3, 16'd6,  4'd10, 4'hF, 1'b0},  // R8 status in error
    {8'h21, 8'd1, 16'd32, 4'd10, 4'hF, 1'b1},  // R8 download in error
    {8'h21, 8'd4, 16'd0,  4'd2,  4'h0, 1'b0},  // R8 clear
    {8'hA1, 8'd2, 16'd64, 4'd9,  4'h0, 1'b0},  // R11 upload
    {8'hA1, 8'd2, 16'd64, 4'd9,  4'h0, 1'b0},  // R11 upload again
    {8'h21, 8'd6, 16'd0,  4'd2,  4'h0, 1'b0},  // R9 abort upload
    {8'h21, 8'd4, 16'd0,  4'd10, 4'hF, 1'b1},  // R13 clear outside error
    {8'h21, 8'd4, 16'd0,  4'd2,  4'h0, 1'b0},
    {8'h21, 8'd3, 16'd6,  4'd10, 4'hF, 1'b1},  // R2 wrong type
    {8'h21, 8'd4, 16'd0,  4'd2,  4'h0, 1'b0},
    {8'hA1, 8'd7, 16'd1,  4'd10, 4'hF, 1'b1},  // R2 unknown code
    {8'h21, 8'd4, 16'd0,  4'd2,  4'h0, 1'b0},
    {8'h21, 8'd0, 16'd0,  4'd10, 4'hF, 1'b1},  // R12 detach in upgrade mode
    {8'h21, 8'd4, 16'd0,  4'd2,  4'h0, 1'b0},
    {8'h21, 8'd6, 16'd0,  4'd2,  4'h0, 1'b0}   // R9 abort in idle
  };

  initial begin
    repeat (20000) @(posedge clk_i);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1
    expect_st("R1 reset state", 4'd2, 4'h0, 1'b0);
    chk({dn_start_o, up_start_o, abort_o, status_vld_o, state_vld_o} == 5'b0, "R1 strobes idle",
        {59'h0, dn_start_o, up_start_o, abort_o, status_vld_o, state_vld_o}, 64'h0);

    for (int i = 0; i < NV; i++) begin
      send(VEC[i][40:33], VEC[i][32:25], 16'h0, VEC[i][24:9]);
      expect_st($sformatf("vector %0d (R2/R6/R8/R9/R11/R13)", i), VEC[i][8:5], VEC[i][4:1], VEC[i][0]);
    end

    // R13 done ignored in idle
    mem_done();
    expect_st("R13 done ignored in idle", 4'd2, 4'h0, 1'b0);

    // R3 download start
    send(8'h21, 8'd1, 16'd5, 16'd32);
    expect_st("R3 download accepted", 4'd3, 4'h0, 1'b0);
    chk(dn_start_o && blk_num_o == 16'd5 && xfer_len_o == 16'd32, "R3 strobe and latch",
        {31'h0, dn_start_o, blk_num_o, xfer_len_o}, {31'h0, 1'b1, 16'd5, 16'd32});
    // R4 busy path, R5 layout
    send(8'hA1, 8'd3, 16'd0, 16'd6);
    expect_st("R4 status to busy", 4'd4, 4'h0, 1'b0);
    chk(status_vld_o && status_resp_o == 48'h00_04_030201_00, "R5 response bytes",
        {16'h0, status_resp_o}, {16'h0, 48'h00_04_030201_00});
    mem_done();
    expect_st("R4 done back to sync", 4'd3, 4'h0, 1'b0);
    send(8'hA1, 8'd3, 16'd0, 16'd6);
    expect_st("R4 sync to download idle", 4'd5, 4'h0, 1'b0);
    // R4 early done
    send(8'h21, 8'd1, 16'd6, 16'd16);
    mem_done();
    expect_st("R4 early done stays sync", 4'd3, 4'h0, 1'b0);
    send(8'hA1, 8'd3, 16'd0, 16'd6);
    expect_st("R4 early done skips busy", 4'd5, 4'h0, 1'b0);
    // R7 manifest path
    send(8'h21, 8'd1, 16'd7, 16'd0);
    expect_st("R7 zero download", 4'd6, 4'h0, 1'b0);
    chk(!dn_start_o, "R7 no start on zero length", {63'h0, dn_start_o}, 64'h0);
    send(8'hA1, 8'd5, 16'd0, 16'd1);
    chk(state_vld_o && state_resp_o == 8'd6 && state_o == 4'd6, "R6 state query in manifest sync",
        {52'h0, state_o, state_resp_o}, {52'h0, 4'd6, 8'd6});
    send(8'hA1, 8'd3, 16'd0, 16'd6);
    expect_st("R7 enter manifest", 4'd7, 4'h0, 1'b0);
    chk(status_resp_o[39:32] == 8'd7, "R5 state byte manifest", {56'h0, status_resp_o[39:32]}, 64'd7);
    mem_done();
    expect_st("R7 wait reset", 4'd8, 4'h0, 1'b0);
    bus_rst();
    expect_st("R7 bus reset to app", 4'd0, 4'h0, 1'b0);
    // R12
    send(8'h21, 8'd0, 16'd100, 16'd0);
    expect_st("R12 detach", 4'd1, 4'h0, 1'b0);
    bus_rst();
    expect_st("R12 reset into upgrade", 4'd2, 4'h0, 1'b0);
    // R10
    send(8'h21, 8'd1, 16'd1, 16'd32);
    send(8'hA1, 8'd3, 16'd0, 16'd6);
    mem_fail(4'h3);
    expect_st("R10 memory error", 4'd10, 4'h3, 1'b0);
    send(8'hA1, 8'd3, 16'd0, 16'd6);
    chk(status_resp_o[7:0] == 8'h03 && status_resp_o[39:32] == 8'd10, "R10 error reported",
        {48'h0, status_resp_o[39:32], status_resp_o[7:0]}, {48'h0, 8'd10, 8'h03});
    send(8'h21, 8'd4, 16'd0, 16'd0);
    expect_st("R8 clear after memory error", 4'd2, 4'h0, 1'b0);
    // R11 upload end
    send(8'hA1, 8'd2, 16'd3, 16'd64);
    chk(up_start_o && blk_num_o == 16'd3, "R11 upload strobe", {47'h0, up_start_o, blk_num_o}, {47'h0, 1'b1, 16'd3});
    mem_done();
    expect_st("R11 upload finished", 4'd2, 4'h0, 1'b0);
    // R9 abort illegal in sync
    send(8'h21, 8'd1, 16'd2, 16'd32);
    send(8'h21, 8'd6, 16'd0, 16'd0);
    expect_st("R9 abort in sync stalls", 4'd10, 4'hF, 1'b1);
    chk(!abort_o, "R9 no abort strobe", {63'h0, abort_o}, 64'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule